// File: doc/BRIEF.md
# Line Latch and Reference-Ladder Steering

This block sits between the per-column capture registers of a display column driver and its output stages. Once per line, a strobe pulse moves the full row of captured gray codes into a line latch. While the strobe is high every output stage is switched off (high-impedance). When the strobe falls, the stages are switched back on and drive the new codes. The strobe is sampled on the system clock and its edges are found synchronously.

Each output also gets a ladder-select bit. This bit tells the converter behind it whether to use the upper or the lower reference ladder. Neighbouring columns always use opposite ladders, and a polarity input, sampled when the strobe rises, swaps the whole pattern.

The transfer into the latch is made on the clock where the strobe has been seen high for the minimum pulse width. The upstream capture array may not change before that point, because the next start pulse cannot arrive earlier. A strobe pulse shorter than the minimum width is rejected and flagged.

Top module: `line_latch_steer`

## Requirements
- R1: After reset all codes read zero, every drive enable is 0 (high-impedance) and the short-strobe flag is 0. Outputs stay off until the first strobe falling edge.
- R2: From the clock after the first high sample of the strobe, and for as long as the strobe is sampled high, every drive enable is 0.
- R3: At the clock where the strobe has been sampled high for MIN_HI_CLKS consecutive clocks (the second clock by default), the whole captured code array is copied into the line latch. The copy appears on the code outputs one clock later. Lane k occupies bits [k*CODE_W +: CODE_W].
- R4: One clock after the first low sample following a high strobe, every drive enable is 1. The outputs then carry the latched codes.
- R5: A ladder-select bit of 1 means the upper reference ladder. Outputs are numbered from 1, and lane k is output k+1. With polarity 0, odd-numbered outputs select the upper ladder and even-numbered outputs select the lower ladder. With polarity 1, the assignment is swapped.
- R6: Polarity is taken only on the clock where the strobe is first sampled high. A change of polarity later in the pulse, or between pulses, has no effect on the ladder selects.
- R7: A strobe pulse sampled high for fewer than MIN_HI_CLKS clocks raises the short-strobe flag for exactly one clock, one clock after its falling edge. No latch transfer happens for that pulse, and the ladder selects are not changed. The drive enables still return to 1 with the previous codes.
- R8: A strobe held high longer than MIN_HI_CLKS makes exactly one transfer. Changes to the capture array after the transfer clock are not taken.
- R9: While the strobe is sampled low, the code outputs and ladder selects do not change, whatever the capture array does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Line strobe, level sampled on clk |
| polarity_i | input | 1 | Ladder polarity, taken at strobe rise |
| cap_codes_i | input | NUM_OUT*CODE_W | Captured gray codes, lane k at [k*CODE_W +: CODE_W] |
| line_codes_o | output | NUM_OUT*CODE_W | Latched codes per output |
| ladder_upper_o | output | NUM_OUT | 1 = upper reference ladder for that output |
| drive_en_o | output | NUM_OUT | 1 = output stage driving, 0 = high-impedance |
| short_strobe_o | output | 1 | One-clock flag for a rejected short strobe |

## Verification
The bench aims at pulses of one clock, where a design that latched on the rising sample would wrongly take new codes instead of keeping the old ones and flagging the error. It also drives long pulses with the capture array rewritten after the transfer clock. A design that latched on every high clock or on the falling edge would show those late values. Polarity is flipped in the middle of each pulse to catch a design that samples it at the transfer or fall clock rather than at the rise. Every lane's ladder select is compared, so an odd/even mix-up shows up as a mismatch at lane 0. Capture data is also churned between pulses to expose any transfer outside the strobe.

// File: rtl/lls_pkg.sv
// Shared helpers for the line latch and ladder steering block.
// Assumes lanes are numbered from 0 while outputs are numbered from 1.
package lls_pkg;

    // Ladder choice for one lane: 1 selects the upper reference ladder.
    // Lane with even index is an odd-numbered output; polarity swaps.
    function automatic logic upper_pick(input int unsigned lane, input logic pol);
        logic odd_numbered;
        odd_numbered = (lane[0] == 1'b0);
        return odd_numbered ^ pol;
    endfunction

endpackage

// File: rtl/lls_strobe_track.sv
// Strobe tracker: samples the strobe on clk, finds its edges, counts high
// clocks, issues the single latch-transfer pulse, keeps polarity from the
// rise sample, runs the shared drive enable and flags short pulses.
// Assumes the capture array is steady for the first MIN_HI_CLKS high clocks.
module lls_strobe_track #(
    parameter int MIN_HI_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic polarity_i,
    output logic stb_q_o,
    output logic commit_o,
    output logic commit_pol_o,
    output logic drive_en_o,
    output logic short_err_o
);
    localparam int CNT_W = $clog2(MIN_HI_CLKS + 1) + 1;
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_HI_CLKS);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic             stb_q;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] hi_next;
    logic             pol_at_rise;
    logic             en_q;
    logic             err_q;
    logic             rise;
    logic             fall;

    // Edge detection against the previous sample.
    assign rise = strobe_i & ~stb_q;
    assign fall = ~strobe_i & stb_q;

    // Next value of the saturating high-time counter.
    always_comb begin
        if (!strobe_i)
            hi_next = '0;
        else if (rise)
            hi_next = ONE_V;
        else if (hi_cnt < MIN_V)
            hi_next = hi_cnt + ONE_V;
        else
            hi_next = hi_cnt;
    end

    // Transfer fires once, when the count first reaches the minimum.
    assign commit_o     = strobe_i && (hi_next == MIN_V) && (rise || (hi_cnt < MIN_V));
    assign commit_pol_o = rise ? polarity_i : pol_at_rise;

    // Strobe sample and high-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            hi_cnt <= '0;
        end else begin
            stb_q  <= strobe_i;
            hi_cnt <= hi_next;
        end
    end

    // Polarity is kept from the rising sample only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_at_rise <= 1'b0;
        else if (rise)
            pol_at_rise <= polarity_i;
    end

    // Shared drive enable: off while high, back on after the fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (strobe_i)
            en_q <= 1'b0;
        else if (fall)
            en_q <= 1'b1;
    end

    // One-clock flag for a pulse that ended below the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= fall && (hi_cnt < MIN_V);
    end

    assign stb_q_o     = stb_q;
    assign drive_en_o  = en_q;
    assign short_err_o = err_q;

    // R2: outputs are off whenever the last strobe sample was high.
    a_r2_off_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> !en_q);

    // R4: the falling sample turns the outputs back on.
    a_r4_on_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_q) |-> en_q);

    // R7: the short-strobe flag lasts a single clock.
    a_r7_err_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    // R7: a flagged pulse coincides with a low strobe sample.
    a_r7_err_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !stb_q);

endmodule

// File: rtl/lls_line_store.sv
// Line latch: holds one gray code per output lane and loads the whole
// captured array on the transfer pulse. Assumes a flat lane-major bus.
module lls_line_store #(
    parameter int NUM_OUT = 384,
    parameter int CODE_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic [NUM_OUT*CODE_W-1:0] cap_i,
    output logic [NUM_OUT*CODE_W-1:0] codes_o
);
    localparam int BUS_W = NUM_OUT * CODE_W;

    logic [BUS_W-1:0] store_q;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        // Per-lane code register, cleared by reset, loaded on transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store_q[k*CODE_W +: CODE_W] <= '0;
            else if (commit_i)
                store_q[k*CODE_W +: CODE_W] <= cap_i[k*CODE_W +: CODE_W];
        end
    end

    assign codes_o = store_q;

endmodule

// File: rtl/lls_ladder_steer.sv
// Ladder steering: keeps the polarity of the last accepted line and turns
// it into one upper/lower ladder select per output lane.
module lls_ladder_steer #(
    parameter int NUM_OUT = 384
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic               pol_i,
    output logic [NUM_OUT-1:0] upper_o
);
    logic pol_line_q;

    // Line polarity, updated only with an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_line_q <= 1'b0;
        else if (commit_i)
            pol_line_q <= pol_i;
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
        assign upper_o[k] = lls_pkg::upper_pick(k, pol_line_q);
    end

endmodule

// File: rtl/line_latch_steer.sv
// Top of the line latch and ladder steering block. Strobe tracking drives
// a single transfer into the line latch and the polarity register; the
// shared enable fans out to every output stage.
module line_latch_steer #(
    parameter int NUM_OUT     = 384,
    parameter int CODE_W      = 6,
    parameter int MIN_HI_CLKS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strobe_i,
    input  logic                      polarity_i,
    input  logic [NUM_OUT*CODE_W-1:0] cap_codes_i,
    output logic [NUM_OUT*CODE_W-1:0] line_codes_o,
    output logic [NUM_OUT-1:0]        ladder_upper_o,
    output logic [NUM_OUT-1:0]        drive_en_o,
    output logic                      short_strobe_o
);
    logic stb_q;
    logic commit;
    logic commit_pol;
    logic drive_en;

    lls_strobe_track #(.MIN_HI_CLKS(MIN_HI_CLKS)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe_i),
        .polarity_i  (polarity_i),
        .stb_q_o     (stb_q),
        .commit_o    (commit),
        .commit_pol_o(commit_pol),
        .drive_en_o  (drive_en),
        .short_err_o (short_strobe_o)
    );

    lls_line_store #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .cap_i   (cap_codes_i),
        .codes_o (line_codes_o)
    );

    lls_ladder_steer #(.NUM_OUT(NUM_OUT)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .pol_i   (commit_pol),
        .upper_o (ladder_upper_o)
    );

    assign drive_en_o = {NUM_OUT{drive_en}};

    // R9: codes hold while the strobe sample is low.
    a_r9_codes_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_q |-> $stable(line_codes_o));

    // R6: ladder selects hold while the strobe sample is low.
    a_r6_ladder_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_q |-> $stable(ladder_upper_o));

    // R7: a rejected pulse left the latch untouched.
    a_r7_no_load_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        short_strobe_o |-> $stable(line_codes_o));

endmodule

// File: tb/line_latch_steer_tb_top.sv
module line_latch_steer_tb_top;
    localparam int N    = 384;
    localparam int W    = 6;
    localparam int MINH = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe_i = 1'b0;
    logic             polarity_i = 1'b0;
    logic [N*W-1:0]   cap_codes_i = '0;
    logic [N*W-1:0]   line_codes_o;
    logic [N-1:0]     ladder_upper_o;
    logic [N-1:0]     drive_en_o;
    logic             short_strobe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [N*W-1:0] exp_codes = '0;
    logic           exp_pol   = 1'b0;

    always #5 clk = ~clk;

    line_latch_steer #(.NUM_OUT(N), .CODE_W(W), .MIN_HI_CLKS(MINH)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .polarity_i(polarity_i),
        .cap_codes_i(cap_codes_i), .line_codes_o(line_codes_o),
        .ladder_upper_o(ladder_upper_o), .drive_en_o(drive_en_o),
        .short_strobe_o(short_strobe_o));

    function automatic logic [N-1:0] exp_ladder(input logic pol);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = ((k % 2) == 0) ^ pol;
        return v;
    endfunction

    function automatic logic [N*W-1:0] rand_codes();
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic chk_en(input string req, input logic exp);
        n_chk++;
        if (drive_en_o !== {N{exp}}) begin
            n_bad++;
            $display("FAIL %s drive_en act=%h exp=all %0b", req, drive_en_o, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        n_chk++;
        if (line_codes_o !== exp_codes) begin
            n_bad++;
            for (int k = 0; k < N; k++)
                if (line_codes_o[k*W +: W] !== exp_codes[k*W +: W]) begin
                    $display("FAIL %s lane %0d act=%h exp=%h", req, k,
                             line_codes_o[k*W +: W], exp_codes[k*W +: W]);
                    break;
                end
        end
    endtask

    task automatic chk_ladder(input string req);
        logic [N-1:0] e;
        e = exp_ladder(exp_pol);
        n_chk++;
        if (ladder_upper_o !== e) begin
            n_bad++;
            $display("FAIL %s ladder act=%h exp=%h", req, ladder_upper_o, e);
        end
    endtask

    // One strobe pulse of hi clocks; pol is flipped and codes churned mid-pulse.
    task automatic pulse(input int hi, input logic pol);
        logic [N*W-1:0] c;
        c = rand_codes();
        @(negedge clk);
        strobe_i = 1'b1; polarity_i = pol; cap_codes_i = c;
        @(posedge clk); @(negedge clk);
        chk_en("R2", 1'b0);
        polarity_i = ~pol;                         // R6: late change ignored
        for (int j = 2; j <= hi; j++) begin
            @(posedge clk); @(negedge clk);
            chk_en("R2", 1'b0);
            if (j == MINH) cap_codes_i = rand_codes();   // R8: after transfer
        end
        strobe_i = 1'b0;
        if (hi >= MINH) begin exp_codes = c; exp_pol = pol; end
        @(posedge clk); @(negedge clk);
        chk_en("R4", 1'b1);
        chk_bit("R7", short_strobe_o, (hi < MINH));
        chk_codes(hi >= MINH ? "R3_R8" : "R7");
        chk_ladder(hi >= MINH ? "R5_R6" : "R7");
        cap_codes_i = rand_codes();                // R9: churn while low
        polarity_i  = $urandom;
        @(posedge clk); @(negedge clk);
        chk_codes("R9");
        chk_ladder("R9");
        chk_bit("R7", short_strobe_o, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cap_codes_i = rand_codes();
        @(posedge clk); @(negedge clk);
        chk_codes("R1");
        chk_en("R1", 1'b0);
        chk_bit("R1", short_strobe_o, 1'b0);
        // Directed corners: short first pulse, exact width, long, swap.
        pulse(1, 1'b1);
        pulse(2, 1'b0);
        pulse(5, 1'b1);
        pulse(1, 1'b0);
        pulse(3, 1'b0);
        for (int i = 0; i < 30; i++)
            pulse(1 + ($urandom % 5), 1'(($urandom % 2)));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule